// File: doc/BRIEF.md
# Radix-8 Booth Wallace-Tree Signed Multiplier

This block multiplies two signed two's-complement operands and returns their full-width signed product. Both operands are captured in registers on a rising clock edge. The product of the captured pair is registered on the following edge. A new pair may be presented every cycle.

The multiplier operand is sign-extended and recoded into radix-8 signed digits, each from -4 to +4. The bit below its least significant bit is taken as zero. Each digit picks one multiple of the multiplicand: 1x, 2x, 3x or 4x. The 3x multiple comes from one dedicated adder that sums 1x and 2x. A negative digit is formed as the bitwise inverse of the chosen multiple, with a 1 added at that row's lowest weight. The rows are sign-handled by a single constant compensation row, so no row carries its sign across the full product width. A tree of full-adder 3:2 compressors reduces all rows to one sum vector and one carry vector. One carry-propagate adder then resolves them into the product.

The operand width is a parameter; the default is 20 bits, which gives a 40-bit product.

Top module: `booth8_mul`

## Requirements
- R1: For any two 20-bit signed operands the 40-bit product equals their exact signed product, including (-2^19) x (-2^19) = +2^38.
- R2: Operands present at a rising edge appear as the product at the next rising edge and stay there for one cycle. A new operand pair is accepted every cycle.
- R3: While the synchronous active-low reset is low at a rising edge, the operand and product registers clear to zero, so the product output reads 0.
- R4: The multiplier is sign-extended and cut into groups of 4 bits that overlap by one bit, with an implicit 0 below bit 0. Group bits {b3,b2,b1,b0} give the digit -4*b3+2*b2+b1+b0. The digits weighted by 8^i add back to the multiplier.
- R5: Each digit selects at most one of the multiples 1x, 2x, 3x, 4x. A digit of 0 yields a zero row.
- R6: The 3x multiple equals three times the sign-extended multiplicand. Products whose multiplier digits include +3 or -3 are correct.
- R7: The 3:2 compressor tree preserves the sum of all rows modulo 2^40, so sum plus carry equals the row total.
- R8: Corner operands give exact results: the most negative value, -1, zero, and the largest positive value, in all pairings.
- R9: With the width parameter set to 6, every one of the 4096 operand pairs yields the exact 12-bit signed product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_a | input | W (20) | Signed multiplicand |
| op_b | input | W (20) | Signed multiplier, Booth-recoded |
| product | output | 2W (40) | Registered signed product |

## Verification
Four checks run on every cycle:
- the recoded digits rebuild the registered multiplier;
- no group selects more than one multiple;
- the 3x adder output is three times the multiplicand;
- the compressor tree keeps the row total intact.

A fifth check compares each registered product against the signed product of the operands captured one cycle earlier.

Some behaviour only the bench scenarios can show: reset clearing, the exact one-cycle timing seen at the pins, back-to-back throughput, and the corner pairings. An exhaustive sweep of a 6-bit build covers every digit combination of a small configuration. The 20-bit build is exercised with directed digit patterns and random pairs.

// File: rtl/booth8_pkg.sv
// Shared types and elaboration-time helpers for the radix-8 Booth multiplier.
// Assumes: operand widths of at least 4 bits.
package booth8_pkg;

    // One recoded digit: sign flag plus one-hot magnitude pick {4x,3x,2x,1x}.
    typedef struct packed {
        logic       neg;
        logic [3:0] pick;
    } bdigit_t;

    // Number of radix-8 digit groups for a w-bit signed multiplier.
    function automatic int groups_for(input int w);
        return (w + 2) / 3;
    endfunction

    // Row count after one layer of 3:2 compression.
    function automatic int csa_step(input int n);
        return (n / 3) * 2 + (n % 3);
    endfunction

    // Layers needed to bring n rows down to two.
    function automatic int csa_levels(input int n);
        int c;
        int l;
        c = n;
        l = 0;
        while (c > 2) begin
            c = csa_step(c);
            l++;
        end
        return l;
    endfunction

    // Row count present at the input of layer lvl.
    function automatic int csa_rows_at(input int n, input int lvl);
        int c;
        c = n;
        for (int i = 0; i < lvl; i++) c = csa_step(c);
        return c;
    endfunction

endpackage

// File: rtl/booth8_recoder.sv
// Radix-8 Booth recoder: turns a signed multiplier into NG digits in -4..+4.
// Assumes: mul is two's complement; the bit below its LSB is taken as 0.
module booth8_recoder
    import booth8_pkg::*;
#(
    parameter int W  = 20,
    parameter int NG = groups_for(W)
) (
    input  logic [W-1:0] mul,
    output bdigit_t      dig [NG]
);
    localparam int EW = 3 * NG + 1;

    logic [EW-1:0] ext;

    // Sign-extend the multiplier and append the implicit zero below bit 0.
    assign ext = EW'({{EW{mul[W-1]}}, mul, 1'b0});

    for (genvar g = 0; g < NG; g++) begin : g_grp
        logic [3:0] grp;
        assign grp = ext[3*g+3 -: 4];

        // Map one 4-bit overlapping group to a sign and a one-hot multiple.
        always_comb begin
            int v;
            int m;
            v = int'(grp[0]) + int'(grp[1]) + 2 * int'(grp[2]) - 4 * int'(grp[3]);
            m = (v < 0) ? -v : v;
            dig[g].neg = (v < 0);
            case (m)
                1:       dig[g].pick = 4'b0001;
                2:       dig[g].pick = 4'b0010;
                3:       dig[g].pick = 4'b0100;
                4:       dig[g].pick = 4'b1000;
                default: dig[g].pick = 4'b0000;
            endcase
        end
    end

endmodule

// File: rtl/booth8_ppgen.sv
// Partial-product row builder for radix-8 Booth digits.
// Produces NG shifted rows, one row of negation carry-ins and one constant
// sign-compensation row; the sum of all rows modulo 2^P is the product.
// Assumes: multiples are L-bit sign-extended values of the multiplicand.
module booth8_ppgen
    import booth8_pkg::*;
#(
    parameter int W  = 20,
    parameter int P  = 2 * W,
    parameter int L  = W + 3,
    parameter int NG = groups_for(W)
) (
    input  logic [L-1:0] m1,
    input  logic [L-1:0] m2,
    input  logic [L-1:0] m3,
    input  logic [L-1:0] m4,
    input  bdigit_t      dig [NG],
    output logic [P-1:0] rows [NG+2]
);
    // Sum of -2^(3g+L-1) over all groups, taken modulo 2^P.
    function automatic logic [P-1:0] comp_const();
        logic [P-1:0] c;
        c = '0;
        for (int g = 0; g < NG; g++)
            c = c - ({{(P-1){1'b0}}, 1'b1} << (3 * g + L - 1));
        return c;
    endfunction

    localparam logic [P-1:0] KCOMP = comp_const();

    logic [P-1:0] corr;

    for (genvar g = 0; g < NG; g++) begin : g_row
        logic [L-1:0] mult;
        logic [L-1:0] pp;
        logic [L-1:0] rbits;
        // Select the multiple named by the one-hot pick.
        assign mult = ({L{dig[g].pick[0]}} & m1) | ({L{dig[g].pick[1]}} & m2)
                    | ({L{dig[g].pick[2]}} & m3) | ({L{dig[g].pick[3]}} & m4);
        // One's complement for negative digits; +1 arrives via corr.
        assign pp    = mult ^ {L{dig[g].neg}};
        // Inverted sign bit; the matching -2^(L-1) lives in KCOMP.
        assign rbits = {~pp[L-1], pp[L-2:0]};
        assign rows[g] = {{(P-L){1'b0}}, rbits} << (3 * g);
    end

    // Collect the negation carry-ins at each row's lowest weight.
    always_comb begin
        corr = '0;
        for (int g = 0; g < NG; g++)
            corr = corr | (P'(dig[g].neg) << (3 * g));
    end

    assign rows[NG]   = corr;
    assign rows[NG+1] = KCOMP;

endmodule

// File: rtl/booth8_csa3.sv
// One 3:2 compression layer slice: a row of full adders over P bits.
// Assumes: arithmetic is modulo 2^P, so the top carry bit is dropped.
module booth8_csa3 #(
    parameter int P = 40
) (
    input  logic [P-1:0] x,
    input  logic [P-1:0] y,
    input  logic [P-1:0] z,
    output logic [P-1:0] s,
    output logic [P-1:0] c
);
    logic [P-1:0] maj;

    // Full-adder sum and majority per bit; the carry moves up one weight.
    assign s   = x ^ y ^ z;
    assign maj = (x & y) | (x & z) | (y & z);
    assign c   = maj << 1;

endmodule

// File: rtl/booth8_csa_tree.sv
// Wallace reduction of NR rows to a sum and a carry vector.
// Each layer groups rows in threes through full-adder compressors and passes
// leftovers down unchanged.
// Assumes: NR >= 3.
module booth8_csa_tree
    import booth8_pkg::*;
#(
    parameter int P  = 40,
    parameter int NR = 9
) (
    input  logic [P-1:0] rows [NR],
    output logic [P-1:0] sum_o,
    output logic [P-1:0] carry_o
);
    localparam int NLEV = csa_levels(NR);

    logic [P-1:0] lv [NLEV+1][NR];

    for (genvar r = 0; r < NR; r++) begin : g_in
        assign lv[0][r] = rows[r];
    end

    for (genvar l = 0; l < NLEV; l++) begin : g_lev
        localparam int NIN  = csa_rows_at(NR, l);
        localparam int NT   = NIN / 3;
        localparam int NREM = NIN % 3;
        localparam int NOUT = 2 * NT + NREM;

        for (genvar j = 0; j < NT; j++) begin : g_fa
            booth8_csa3 #(.P(P)) u_csa (
                .x (lv[l][3*j]),
                .y (lv[l][3*j+1]),
                .z (lv[l][3*j+2]),
                .s (lv[l+1][2*j]),
                .c (lv[l+1][2*j+1])
            );
        end
        for (genvar r = 0; r < NREM; r++) begin : g_pass
            assign lv[l+1][2*NT+r] = lv[l][3*NT+r];
        end
        for (genvar k = NOUT; k < NR; k++) begin : g_idle
            assign lv[l+1][k] = '0;
        end
    end

    assign sum_o   = lv[NLEV][0];
    assign carry_o = lv[NLEV][1];

endmodule

// File: rtl/booth8_mul.sv
// Registered signed multiplier: radix-8 Booth recoding, 3:2 Wallace tree,
// one carry-propagate adder. Operands are captured on one edge; their
// product is registered on the next.
// Assumes: synchronous active-low reset; W <= 31 for the embedded checks.
module booth8_mul
    import booth8_pkg::*;
#(
    parameter int W = 20
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [W-1:0]   op_a,
    input  logic [W-1:0]   op_b,
    output logic [2*W-1:0] product
);
    localparam int P  = 2 * W;
    localparam int L  = W + 3;
    localparam int NG = groups_for(W);
    localparam int NR = NG + 2;

    logic [W-1:0] a_q;
    logic [W-1:0] b_q;
    logic [P-1:0] prod_q;
    logic [L-1:0] m1, m2, m3, m4;
    bdigit_t      dig [NG];
    logic [P-1:0] rows [NR];
    logic [P-1:0] t_sum;
    logic [P-1:0] t_carry;
    logic [P-1:0] prod_d;

    // Capture operands and the finished product; clear all on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q    <= '0;
            b_q    <= '0;
            prod_q <= '0;
        end else begin
            a_q    <= op_a;
            b_q    <= op_b;
            prod_q <= prod_d;
        end
    end

    // Multiplicand multiples; 3x comes from a single dedicated adder.
    assign m1 = L'($signed(a_q));
    assign m2 = m1 << 1;
    assign m4 = m1 << 2;
    assign m3 = m1 + m2;

    booth8_recoder #(.W(W), .NG(NG)) u_rec (
        .mul (b_q),
        .dig (dig)
    );

    booth8_ppgen #(.W(W), .P(P), .L(L), .NG(NG)) u_pp (
        .m1   (m1),
        .m2   (m2),
        .m3   (m3),
        .m4   (m4),
        .dig  (dig),
        .rows (rows)
    );

    booth8_csa_tree #(.P(P), .NR(NR)) u_tree (
        .rows    (rows),
        .sum_o   (t_sum),
        .carry_o (t_carry)
    );

    // Final carry-propagate adder.
    assign prod_d  = t_sum + t_carry;
    assign product = prod_q;

    // ---------------- embedded checks ----------------
    logic [P-1:0] ref_prod;
    logic [P-1:0] row_total;
    longint       recon;

    // Behavioural signed product of the captured operands.
    always_comb ref_prod = P'(longint'($signed(a_q)) * longint'($signed(b_q)));

    // Plain sum of every row entering the tree.
    always_comb begin
        row_total = '0;
        for (int r = 0; r < NR; r++) row_total = row_total + rows[r];
    end

    // Rebuild the multiplier from the recoded digits.
    always_comb begin
        recon = 0;
        for (int g = 0; g < NG; g++) begin
            longint m;
            m = dig[g].pick[0] ? 1 : dig[g].pick[1] ? 2 :
                dig[g].pick[2] ? 3 : dig[g].pick[3] ? 4 : 0;
            recon = recon + (dig[g].neg ? -m : m) * (longint'(1) << (3 * g));
        end
    end

    // R1 and R2: product equals the signed product of last cycle's operands.
    p_product_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> prod_q == $past(ref_prod))
        else $error("product mismatch");

    p_recode_r4: assert property (@(posedge clk) disable iff (!rst_n)
        recon == longint'($signed(b_q)))
        else $error("digits do not rebuild multiplier");

    for (genvar g = 0; g < NG; g++) begin : g_chk
        p_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(dig[g].pick))
            else $error("more than one multiple selected");
    end

    p_triple_r6: assert property (@(posedge clk) disable iff (!rst_n)
        longint'($signed(m3)) == 3 * longint'($signed(a_q)))
        else $error("3x multiple wrong");

    p_tree_sum_r7: assert property (@(posedge clk) disable iff (!rst_n)
        row_total == t_sum + t_carry)
        else $error("compressor tree lost value");

endmodule

// File: tb/booth8_mul_bench.sv
module booth8_mul_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [19:0] a20, b20;
    logic [39:0] p20;
    logic [5:0]  a6, b6;
    logic [11:0] p6;
    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    booth8_mul #(.W(20)) u_booth8_mul (
        .clk(clk), .rst_n(rst_n), .op_a(a20), .op_b(b20), .product(p20)
    );

    booth8_mul #(.W(6)) u_booth8_mul_small (
        .clk(clk), .rst_n(rst_n), .op_a(a6), .op_b(b6), .product(p6)
    );

    function automatic logic [39:0] exp20(input logic [19:0] a, input logic [19:0] b);
        return 40'(longint'($signed(a)) * longint'($signed(b)));
    endfunction

    function automatic logic [11:0] exp6(input logic [5:0] a, input logic [5:0] b);
        return 12'(longint'($signed(a)) * longint'($signed(b)));
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] expv);
        n_run++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    task automatic run20(input logic [19:0] a, input logic [19:0] b, input string tag);
        @(negedge clk);
        a20 = a;
        b20 = b;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        chk(tag, 64'(p20), 64'(exp20(a, b)));
    endtask

    task automatic run6(input logic [5:0] a, input logic [5:0] b, input string tag);
        @(negedge clk);
        a6 = a;
        b6 = b;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        chk(tag, 64'(p6), 64'(exp6(a, b)));
    endtask

    initial begin
        logic [19:0] va [8];
        logic [19:0] vb [8];
        rst_n = 1'b0;
        a20 = 20'hABCDE;
        b20 = 20'h54321;
        a6  = 6'h2B;
        b6  = 6'h15;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R3 reset 20-bit", 64'(p20), 64'd0);
        chk("R3 reset 6-bit", 64'(p6), 64'd0);
        rst_n = 1'b1;

        // R2: one-cycle latency seen at the pins.
        run20(20'd3, 20'd4, "R2 setup");
        @(negedge clk);
        a20 = 20'd5;
        b20 = 20'd7;
        @(posedge clk);
        @(negedge clk);
        chk("R2 old product held", 64'(p20), 64'd12);
        @(posedge clk);
        @(negedge clk);
        chk("R2 new product", 64'(p20), 64'd35);

        // R2: back-to-back pairs, one per cycle.
        for (int k = 0; k < 8; k++) begin
            va[k] = 20'($urandom);
            vb[k] = 20'($urandom);
        end
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (k >= 2) chk("R2 streaming", 64'(p20), 64'(exp20(va[k-2], vb[k-2])));
            if (k < 8) begin
                a20 = va[k];
                b20 = vb[k];
            end
        end

        // R8 corners.
        run20(20'h80000, 20'h80000, "R8 minneg*minneg");
        run20(20'h80000, 20'h7FFFF, "R8 minneg*maxpos");
        run20(20'h7FFFF, 20'h7FFFF, "R8 maxpos*maxpos");
        run20(20'hFFFFF, 20'hFFFFF, "R8 -1*-1");
        run20(20'hFFFFF, 20'h80000, "R8 -1*minneg");
        run20(20'h80000, 20'hFFFFF, "R8 minneg*-1");
        run20(20'h12345, 20'hFFFFF, "R8 x*-1");
        run20(20'h00000, 20'h7FFFF, "R8 zero*max");
        run20(20'h80000, 20'h00000, "R8 minneg*zero");
        run20(20'h00001, 20'h80000, "R1 one*minneg");

        // R4: repeated nibble patterns drive every digit value into every group.
        for (int v = 0; v < 16; v++) begin
            run20(20'($urandom), {5{4'(v)}}, "R4 digit pattern");
            run20(20'h80000, {5{4'(v)}}, "R4 digit pattern minneg");
        end

        // R5: sparse multipliers leave most digits at zero.
        for (int g = 0; g < 7; g++) begin
            run20(20'($urandom), 20'(longint'(1) << (3 * g)), "R5 single digit");
            run20(20'h7FFFF, 20'h00000, "R5 all-zero digits");
        end

        // R6: multipliers holding +3 and -3 digits.
        run20(20'h7FFFF, 20'd3, "R6 digit +3");
        run20(20'h80000, 20'd5, "R6 digit -3");
        run20(20'h80000, 20'hFFFFD, "R6 minus three");
        run20(20'h7FFFF, 20'hFFFFB, "R6 minus five");
        run20(20'h2A5A5, 20'h5B6DB, "R6 mixed threes");

        // R1 and R7: random pairs.
        for (int k = 0; k < 1500; k++)
            run20(20'($urandom), 20'($urandom), "R1 R7 random");

        // R9: exhaustive sweep of the 6-bit build.
        for (int ia = 0; ia < 64; ia++)
            for (int ib = 0; ib < 64; ib++)
                run6(6'(ia), 6'(ib), "R9 exhaustive");

        // R3: reset in mid-run clears a nonzero product.
        run20(20'h7FFFF, 20'h7FFFF, "R3 pre-reset product");
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R3 mid-run reset", 64'(p20), 64'd0);
        @(posedge clk);
        @(negedge clk);
        chk("R3 reset held", 64'(p20), 64'd0);
        rst_n = 1'b1;
        run20(20'h00007, 20'hFFFFA, "R3 recovery");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule